// File: doc/BRIEF.md
# Display Interrupt Request Unit

This block collects the interrupt sources of a display pipeline and combines them into one request line. It has three sources. The first is a frame event taken at a programmable point of the vertical timing. The second is a FIFO fill-level condition, watched across five overlay windows. The third is a completion pulse from a command-mode parallel panel port. Each source has its own sticky pending bit. Software clears a pending bit by writing a 1 to it.

The block has one control word, loaded by a write strobe. It carries a master enable, one enable per source class, the vertical-phase selector, a per-window FIFO mask and a fill-level code. The timing generator supplies one-cycle strobes at the start of back porch, at sync and at the start of front porch. Each window FIFO reports its occupancy as a count from 0 to `FIFO_DEPTH`.

Top module: `disp_irq_unit`

## Requirements
- R1: After reset, every control bit, every pending bit and `irq_o` are 0.
- R2: The frame selector sits in control bits [14:13] and picks which strobe sets the frame pending bit (`pend_o[1]`). The codes are: 01 for back porch start, 10 for sync, 11 for front porch start. Code 00 selects no strobe. A strobe that is not selected has no effect.
- R3: The frame enable sits in control bit 12. When it is 0, the frame pending bit never sets.
- R4: The level code sits in control bits [4:2]. It compares the occupancy `occ` against `FIFO_DEPTH` (D). Code 000 means occ*4 <= D. Code 001 means occ*2 <= D. Code 010 means occ*4 <= 3*D. Code 011 means occ == 0. Code 100 means occ == D.
- R5: Level codes 101, 110 and 111 never match.
- R6: The window mask uses control bits 5, 6, 9, 10 and 11 for windows 0 to 4. A window takes part only while its bit is 1. Bits 7 and 8 select nothing.
- R7: The FIFO enable sits in control bit 1. When it is 0, the FIFO pending bit (`pend_o[0]`) never sets.
- R8: The FIFO pending bit sets on the cycle after the combined FIFO condition goes from false to true. The combined condition is the FIFO enable AND any masked window matching. A condition that stays true does not set the bit again after it is cleared.
- R9: A pending-clear write clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R10: When a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R11: A completion pulse on `i80_done_i` sets `pend_o[2]` on the next cycle. No enable other than the master enable affects this source.
- R12: `irq_o` equals control bit 0 (the master enable) AND the OR of the three pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Loads the control word |
| ctrl_wdata_i | input | 15 | Control word data |
| pend_clr_we_i | input | 1 | Pending clear strobe |
| pend_clr_i | input | 3 | Write-1-to-clear mask for the pending bits |
| vbp_i | input | 1 | Strobe at back porch start |
| vsync_i | input | 1 | Strobe at vertical sync |
| vfp_i | input | 1 | Strobe at front porch start |
| fifo_occ_i | input | 5*OCC_W | Window occupancies, window 0 in the low bits |
| i80_done_i | input | 1 | Command-port completion pulse |
| pend_o | output | 3 | Pending bits: [0] FIFO, [1] frame, [2] completion |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after threshold boundaries. It places occupancies exactly on each fractional limit and one count past it. A comparator with `<` in place of `<=`, or one that is off by one, would miss or add a pending set there. It leaves the FIFO condition true across a clear; a level-sensitive detector would set the bit again at once. It sets and clears the same bit in one cycle; a design that lets the clear win would lose the event. It also fills every window while only the reserved mask bits are 1. It drives strobes that are not selected. Both must leave the pending bits untouched, and a wrong bit mapping would show up there.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int NUM_WIN = 5;
  localparam int CTRL_W  = 15;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    FRM_NONE  = 2'b00,
    FRM_BP    = 2'b01,
    FRM_SYNC  = 2'b10,
    FRM_FP    = 2'b11
  } frm_sel_e;

  typedef enum logic [2:0] {
    LVL_Q1    = 3'b000,
    LVL_HALF  = 3'b001,
    LVL_Q3    = 3'b010,
    LVL_EMPTY = 3'b011,
    LVL_FULL  = 3'b100
  } lvl_sel_e;

  typedef struct packed {
    frm_sel_e    frm_sel;    // [14:13]
    logic        frm_en;     // [12]
    logic [6:0]  mask_raw;   // [11:5]
    logic [2:0]  lvl_sel;    // [4:2]
    logic        fifo_en;    // [1]
    logic        master_en;  // [0]
  } ctrl_t;

  localparam int SRC_FIFO = 0;
  localparam int SRC_FRM  = 1;
  localparam int SRC_DONE = 2;

  // raw mask bits 2,3 (control 7,8) are reserved
  function automatic logic [NUM_WIN-1:0] win_mask(input logic [6:0] raw);
    return {raw[6], raw[5], raw[4], raw[1], raw[0]};
  endfunction
endpackage

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/disp_irq_frm.sv
module disp_irq_frm
  import disp_irq_pkg::*;
(
  input  logic     en_i,
  input  frm_sel_e sel_i,
  input  logic     vbp_i,
  input  logic     vsync_i,
  input  logic     vfp_i,
  output logic     hit_o
);
  logic strobe;

  always_comb begin
    unique case (sel_i)
      FRM_BP:   strobe = vbp_i;
      FRM_SYNC: strobe = vsync_i;
      FRM_FP:   strobe = vfp_i;
      default:  strobe = 1'b0;
    endcase
  end

  assign hit_o = en_i & strobe;
endmodule

// File: rtl/disp_irq_fifo_det.sv
module disp_irq_fifo_det
  import disp_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [2:0]               lvl_sel_i,
  input  logic [6:0]               mask_raw_i,
  input  logic [NUM_WIN*OCC_W-1:0] occ_i,
  output logic                     rise_o
);
  localparam int CW = OCC_W + 3;
  localparam logic [CW-1:0] D1 = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] D3 = CW'(3 * FIFO_DEPTH);

  logic [NUM_WIN-1:0] mask;
  logic [NUM_WIN-1:0] match;
  logic               hit, hit_q;
  logic               unused_rsvd;

  assign mask        = win_mask(mask_raw_i);
  assign unused_rsvd = ^mask_raw_i[3:2];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [OCC_W-1:0] occ;
    logic [CW-1:0]    occ_x1, occ_x2, occ_x4;
    logic             met;

    assign occ    = occ_i[w*OCC_W +: OCC_W];
    assign occ_x1 = CW'(occ);
    assign occ_x2 = occ_x1 << 1;
    assign occ_x4 = occ_x1 << 2;

    always_comb begin
      unique case (lvl_sel_i)
        LVL_Q1:    met = (occ_x4 <= D1);
        LVL_HALF:  met = (occ_x2 <= D1);
        LVL_Q3:    met = (occ_x4 <= D3);
        LVL_EMPTY: met = (occ_x1 == '0);
        LVL_FULL:  met = (occ_x1 == D1);
        default:   met = 1'b0;
      endcase
    end

    assign match[w] = mask[w] & met;
  end

  assign hit = en_i & (|match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  assign rise_o = hit & ~hit_q;
endmodule

// File: rtl/disp_irq_pend.sv
module disp_irq_pend
  import disp_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_i : '0;

  // set overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_eff) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
  import disp_irq_pkg::*;
#(
  parameter int  FIFO_DEPTH = 64,
  localparam int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctrl_we_i,
  input  logic [CTRL_W-1:0]        ctrl_wdata_i,
  input  logic                     pend_clr_we_i,
  input  logic [NUM_SRC-1:0]       pend_clr_i,
  input  logic                     vbp_i,
  input  logic                     vsync_i,
  input  logic                     vfp_i,
  input  logic [NUM_WIN*OCC_W-1:0] fifo_occ_i,
  input  logic                     i80_done_i,
  output logic [NUM_SRC-1:0]       pend_o,
  output logic                     irq_o
);
  ctrl_t              ctrl;
  logic               master_en, frm_en, fifo_en;
  logic               frm_hit, fifo_rise;
  logic [NUM_SRC-1:0] set_vec;

  disp_irq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  assign master_en = ctrl.master_en;
  assign frm_en    = ctrl.frm_en;
  assign fifo_en   = ctrl.fifo_en;

  disp_irq_frm u_frm (
    .en_i    (frm_en),
    .sel_i   (ctrl.frm_sel),
    .vbp_i   (vbp_i),
    .vsync_i (vsync_i),
    .vfp_i   (vfp_i),
    .hit_o   (frm_hit)
  );

  disp_irq_fifo_det #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .OCC_W      (OCC_W)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (fifo_en),
    .lvl_sel_i  (ctrl.lvl_sel),
    .mask_raw_i (ctrl.mask_raw),
    .occ_i      (fifo_occ_i),
    .rise_o     (fifo_rise)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_FIFO] = fifo_rise;
    set_vec[SRC_FRM]  = frm_hit;
    set_vec[SRC_DONE] = i80_done_i;
  end

  disp_irq_pend u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_we_i (pend_clr_we_i),
    .clr_i    (pend_clr_i),
    .pend_o   (pend_o)
  );

  assign irq_o = master_en & (|pend_o);
endmodule

// File: rtl/disp_irq_chk.sv
module disp_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       i80_done_i,
  input logic       pend_clr_we_i,
  input logic [2:0] pend_clr_i,
  input logic [2:0] pend_o,
  input logic       irq_o,
  input logic       master_en,
  input logic       frm_en,
  input logic       fifo_en
);
  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en |-> !irq_o); // R12
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == 3'b000) |-> !irq_o); // R12
  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i80_done_i |=> pend_o[2]); // R11
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i80_done_i && pend_clr_we_i && pend_clr_i[2]) |=> pend_o[2]); // R10
  AST_CLR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_we_i && pend_clr_i[2] && !i80_done_i) |=> !pend_o[2]); // R9
  AST_CLR_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_we_i && !pend_clr_i[2] && pend_o[2]) |=> pend_o[2]); // R9
  AST_FRM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_en |=> !$rose(pend_o[1])); // R3
  AST_FIFO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |=> !$rose(pend_o[0])); // R7
endmodule

bind disp_irq_unit disp_irq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .i80_done_i    (i80_done_i),
  .pend_clr_we_i (pend_clr_we_i),
  .pend_clr_i    (pend_clr_i),
  .pend_o        (pend_o),
  .irq_o         (irq_o),
  .master_en     (master_en),
  .frm_en        (frm_en),
  .fifo_en       (fifo_en)
);

// File: tb/disp_irq_unit_tb.sv
module disp_irq_unit_tb;
  localparam int D  = 64;
  localparam int OW = 7;
  localparam int NW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ctrl_we_i = 1'b0;
  logic [14:0]   ctrl_wdata_i = '0;
  logic          pend_clr_we_i = 1'b0;
  logic [2:0]    pend_clr_i = '0;
  logic          vbp_i = 1'b0, vsync_i = 1'b0, vfp_i = 1'b0;
  logic          i80_done_i = 1'b0;
  logic [NW*OW-1:0] fifo_occ_i;
  logic [2:0]    pend_o;
  logic          irq_o;

  int occ [NW];
  always_comb
    for (int w = 0; w < NW; w++) fifo_occ_i[w*OW +: OW] = OW'(occ[w]);

  always #5 clk_i = ~clk_i;

  disp_irq_unit #(.FIFO_DEPTH(D)) u_dut (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .pend_clr_we_i, .pend_clr_i,
    .vbp_i, .vsync_i, .vfp_i, .fifo_occ_i, .i80_done_i, .pend_o, .irq_o
  );

  // reference state
  logic [14:0] m_ctrl = '0;
  logic [2:0]  m_pend = '0;
  bit          m_prev = 1'b0;
  int          n_vec = 0, n_bad = 0;
  string       req = "R1";
  bit          done = 1'b0;
  int          win_bit [NW] = '{5, 6, 9, 10, 11};

  function automatic bit lvl_ok(int o, int code);
    case (code)
      0: return o * 4 <= D;
      1: return o * 2 <= D;
      2: return o * 4 <= 3 * D;
      3: return o == 0;
      4: return o == D;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [14:0] cw(bit m, bit fe, int lvl, logic [6:0] mraw, bit fre, int sel);
    return {2'(sel), fre, mraw, 3'(lvl), fe, m};
  endfunction

  task automatic tick();
    bit hit, fsel;
    logic [2:0] setv, clrv;
    @(posedge clk_i);
    hit = 1'b0;
    if (m_ctrl[1])
      for (int w = 0; w < NW; w++)
        if (m_ctrl[win_bit[w]] && lvl_ok(occ[w], int'(m_ctrl[4:2]))) hit = 1'b1;
    case (m_ctrl[14:13])
      2'b01: fsel = vbp_i;
      2'b10: fsel = vsync_i;
      2'b11: fsel = vfp_i;
      default: fsel = 1'b0;
    endcase
    setv = {i80_done_i, m_ctrl[12] & fsel, hit & ~m_prev};
    clrv = pend_clr_we_i ? pend_clr_i : 3'b000;
    m_pend = (m_pend & ~clrv) | setv;
    m_prev = hit;
    if (ctrl_we_i) m_ctrl = ctrl_wdata_i;
    #2;
    n_vec++;
    if (pend_o !== m_pend || irq_o !== (m_ctrl[0] & |m_pend)) begin
      n_bad++;
      $display("FAIL %s: pend=%b irq=%b expected pend=%b irq=%b", req, pend_o, irq_o,
               m_pend, m_ctrl[0] & |m_pend);
    end
    ctrl_we_i = 0; pend_clr_we_i = 0; pend_clr_i = '0;
    vbp_i = 0; vsync_i = 0; vfp_i = 0; i80_done_i = 0;
  endtask

  task automatic wr_ctrl(logic [14:0] v);
    ctrl_we_i = 1; ctrl_wdata_i = v; tick();
  endtask

  task automatic clr(logic [2:0] v);
    pend_clr_we_i = 1; pend_clr_i = v; tick();
  endtask

  task automatic set_occ(int w, int v);
    occ[w] = v; tick(); tick();
  endtask

  initial begin
    for (int w = 0; w < NW; w++) occ[w] = 32;
    #23;
    req = "R1"; n_vec++;
    if (pend_o !== 3'b000 || irq_o !== 1'b0) begin
      n_bad++; $display("FAIL R1: pend=%b irq=%b expected 000 0", pend_o, irq_o);
    end
    rst_ni = 1; tick(); tick();

    // R2 / R3: frame phase selection and gating
    req = "R2";
    wr_ctrl(cw(1, 0, 0, 7'h00, 1, 1));
    vsync_i = 1; tick(); vfp_i = 1; tick(); vbp_i = 1; tick(); clr(3'b010);
    wr_ctrl(cw(1, 0, 0, 7'h00, 1, 2));
    vbp_i = 1; vfp_i = 1; tick(); vsync_i = 1; tick(); clr(3'b010);
    wr_ctrl(cw(1, 0, 0, 7'h00, 1, 3));
    vbp_i = 1; vsync_i = 1; tick(); vfp_i = 1; tick(); clr(3'b010);
    wr_ctrl(cw(1, 0, 0, 7'h00, 1, 0));
    vbp_i = 1; vsync_i = 1; vfp_i = 1; tick();
    req = "R3";
    wr_ctrl(cw(1, 0, 0, 7'h00, 0, 1));
    vbp_i = 1; tick(); vbp_i = 1; tick();

    // R11, R9, R10
    req = "R11";
    i80_done_i = 1; tick(); tick();
    req = "R9";
    clr(3'b011); clr(3'b000); clr(3'b100); tick();
    req = "R10";
    i80_done_i = 1; tick();
    i80_done_i = 1; pend_clr_we_i = 1; pend_clr_i = 3'b100; tick(); tick();
    clr(3'b100);

    // R4 / R8: thresholds on window 0, edge behaviour
    req = "R4";
    wr_ctrl(cw(1, 1, 0, 7'h01, 0, 0));
    set_occ(0, 17); set_occ(0, 16);
    req = "R8";
    clr(3'b001); tick(); tick();
    set_occ(0, 17); set_occ(0, 16); clr(3'b001);
    req = "R4";
    wr_ctrl(cw(1, 1, 1, 7'h01, 0, 0));
    set_occ(0, 33); set_occ(0, 32); clr(3'b001);
    wr_ctrl(cw(1, 1, 2, 7'h01, 0, 0));
    set_occ(0, 49); set_occ(0, 48); clr(3'b001);
    wr_ctrl(cw(1, 1, 3, 7'h01, 0, 0));
    set_occ(0, 1); set_occ(0, 0); clr(3'b001);
    wr_ctrl(cw(1, 1, 4, 7'h01, 0, 0));
    set_occ(0, 63); set_occ(0, 64); clr(3'b001);

    // R5: unused level codes
    req = "R5";
    for (int c = 5; c < 8; c++) begin
      wr_ctrl(cw(1, 1, c, 7'h7F, 0, 0));
      set_occ(0, 0); set_occ(0, 64); set_occ(0, 10);
    end

    // R6: reserved mask bits, window 4 mapping
    req = "R6";
    for (int w = 0; w < NW; w++) occ[w] = 64;
    wr_ctrl(cw(1, 1, 4, 7'h0C, 0, 0));
    tick(); tick();
    for (int w = 0; w < NW; w++) occ[w] = 10;
    wr_ctrl(cw(1, 1, 4, 7'h40, 0, 0));
    set_occ(3, 64); set_occ(4, 64); clr(3'b001);
    wr_ctrl(cw(1, 1, 3, 7'h10, 0, 0));
    set_occ(1, 0); set_occ(2, 0); clr(3'b001);

    // R7: FIFO enable gating
    req = "R7";
    wr_ctrl(cw(1, 0, 3, 7'h7F, 0, 0));
    set_occ(0, 0); set_occ(3, 0); tick();

    // R12: master enable
    req = "R12";
    i80_done_i = 1; tick();
    wr_ctrl(cw(0, 0, 0, 7'h00, 0, 0)); tick();
    wr_ctrl(cw(1, 0, 0, 7'h00, 0, 0)); tick();
    clr(3'b111); tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule